// File: doc/BRIEF.md
# Cascaded Buck Charger Duty Controller

This block is the digital regulator of a buck battery charger. It holds a free-running PWM carrier and two nested loops. The inner loop is proportional only and runs once per PWM period. It reads the inductor current at the clock where the switch is about to open, which is where the current peaks. It then computes a new duty value, and the carrier applies that value from the start of the next period. The outer loop runs much more slowly. It filters the battery voltage, then sets the current target with a PI law. A droop term lowers the voltage target in proportion to the measured current.

The carrier period and the outer-loop rate are set independently. The outer loop fires once every `cfg_vdiv + 1` carrier periods, so each current target governs many switching pulses. Duty limits keep the switch inside a safe window. Any clock in which the switch is on and the current reading is above an absolute limit ends the pulse at once. The ADC and the power stage are outside the block: it takes parallel samples that are already converted and drives a single gate-level output.

Top module: `buck_cascade_ctrl`

## Requirements
- R1: The carrier counter counts 0 to `cfg_period` and so repeats every `cfg_period + 1` clocks. `pwm_out` is high during the first `duty_now` clocks of each period, or during the whole period when `duty_now` exceeds `cfg_period`.
- R2: `sample_strobe` pulses exactly once per period. It falls in the last clock of the high phase (counter equal to `duty_now - 1`), or in the last clock of the period when `duty_now` is 0 or exceeds `cfg_period`.
- R3: At the strobe the new duty is (`cfg_kp_i` × (`i_set` − `adc_i`)) arithmetically shifted right by 4 (floor), and is then limited as R5 states.
- R4: A new duty value is held in a shadow register and reaches `duty_now` only at the start of a period. `duty_now` never changes within a period.
- R5: The computed duty is forced into [`cfg_duty_min`, `cfg_duty_max`]. The minimum is tested first.
- R6: When `pwm_out` is high and `adc_i` > `cfg_ilimit` in the same clock, `pwm_out` is low from the next clock until the period ends, and `oc_trip` is high for that span.
- R7: The outer loop updates once every `cfg_vdiv + 1` periods. `i_set` changes only in the clock after such an update strobe.
- R8: The voltage measurement is filtered once per period with vf ← vf + ((`adc_v` − vf) >>> 2).
- R9: On each update: err = `cfg_vref` − droop − vf; the integrator gains (`cfg_ki_v`·err)>>>4 and is limited to 0..4095; `i_set` = (`cfg_kp_v`·err)>>>4 + integrator, limited to 0..4095.
- R10: The droop term is (`cfg_kdroop` × last sampled current) >> 4.
- R11: The integrator holds its value at any update where the most recent duty computation was limited by R5.
- R12: While `rst_n` is low, `pwm_out`, `oc_trip`, `duty_now` and `i_set` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_period | input | CNT_W | Last counter value of a period |
| cfg_duty_min | input | CNT_W | Lowest permitted duty |
| cfg_duty_max | input | CNT_W | Highest permitted duty |
| cfg_ilimit | input | DW | Absolute current limit |
| cfg_vref | input | DW | Voltage target |
| cfg_kp_i | input | GW | Current loop gain, 4 fraction bits |
| cfg_kp_v | input | GW | Voltage proportional gain, 4 fraction bits |
| cfg_ki_v | input | GW | Voltage integral gain, 4 fraction bits |
| cfg_kdroop | input | GW | Droop gain, 4 fraction bits |
| cfg_vdiv | input | DIV_W | Periods per voltage update, minus one |
| adc_i | input | DW | Inductor current sample |
| adc_v | input | DW | Battery voltage sample |
| pwm_out | output | 1 | Switch drive |
| sample_strobe | output | 1 | Current sampling instant |
| duty_now | output | CNT_W | Duty of the running period |
| oc_trip | output | 1 | Pulse ended by overcurrent |
| i_set | output | DW | Current setpoint from the voltage loop |

## Verification
The overcurrent cut-off and the current-loop sampling instant can both occur within one period. The cut-off may also fire before the sampling clock is reached. The bench sets a current above the limit, so the pulse is cut after its first clock. It then confirms three things: only one high clock occurs, `oc_trip` is high inside the period, and the strobe still lands at the position the computed duty gives. This shows that the cut-off removes the pulse without removing that period's loop update. When the limit is restored, the full pulse width returns.

// File: rtl/buck_pkg.sv
// Shared constants for the cascaded buck controller.
// Assumes: all loop gains carry GAIN_SH fraction bits.
package buck_pkg;
    localparam int GAIN_SH = 4;   // fraction bits of every gain input
    localparam int FILT_SH = 2;   // voltage filter weight is 1/2**FILT_SH
endpackage

// File: rtl/bk_pwm_carrier.sv
// PWM carrier: counter, shadowed duty, sampling instant and overcurrent cut-off.
// Assumes: duty_calc is valid in the clock in which samp is high.
module bk_pwm_carrier #(
    parameter int CNT_W = 8,
    parameter int DW    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] duty_calc,
    input  logic [DW-1:0]    adc_i,
    input  logic [DW-1:0]    ilimit,
    output logic             pwm_out,
    output logic             samp,
    output logic             wrap,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] duty_act,
    output logic             kill
);
    logic [CNT_W-1:0] shadow;
    logic [CNT_W-1:0] samp_pt;

    // last counter value of the period
    always_comb wrap = (cnt >= period);

    // sampling point: final high clock, or final clock when no edge falls inside
    always_comb begin
        if (duty_act == '0 || duty_act > period)
            samp_pt = period;
        else
            samp_pt = duty_act - CNT_W'(1);
        samp = (cnt == samp_pt);
    end

    // switch drive, gated by the overcurrent latch
    always_comb pwm_out = (cnt < duty_act) && !kill;

    // counter, shadow load and duty transfer at the period boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            shadow   <= '0;
            duty_act <= '0;
        end else begin
            cnt <= wrap ? '0 : cnt + CNT_W'(1);
            if (samp)
                shadow <= duty_calc;
            if (wrap)
                duty_act <= samp ? duty_calc : shadow;
        end
    end

    // overcurrent latch: set during a pulse, cleared at the period end
    always_ff @(posedge clk) begin
        if (!rst_n)
            kill <= 1'b0;
        else if (wrap)
            kill <= 1'b0;
        else if (pwm_out && (adc_i > ilimit))
            kill <= 1'b1;
    end
endmodule

// File: rtl/bk_cur_loop.sv
// Proportional current loop: duty from the current error, with duty limits.
// Assumes: samp marks the single sampling clock of each period.
module bk_cur_loop #(
    parameter int CNT_W = 8,
    parameter int DW    = 12,
    parameter int GW    = 8,
    parameter int SH    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp,
    input  logic [DW-1:0]    adc_i,
    input  logic [DW-1:0]    i_set,
    input  logic [GW-1:0]    kp,
    input  logic [CNT_W-1:0] dmin,
    input  logic [CNT_W-1:0] dmax,
    output logic [CNT_W-1:0] duty_calc,
    output logic [DW-1:0]    i_samp,
    output logic             sat
);
    localparam int PW = DW + GW + 2;

    logic signed [PW-1:0] err, gain, prod, raw, lo, hi;
    logic                 clip;

    // proportional law followed by the duty window
    always_comb begin
        err  = PW'(i_set) - PW'(adc_i);
        gain = PW'(kp);
        prod = err * gain;
        raw  = prod >>> SH;
        lo   = PW'(dmin);
        hi   = PW'(dmax);
        if (raw < lo) begin
            duty_calc = dmin;
            clip      = 1'b1;
        end else if (raw > hi) begin
            duty_calc = dmax;
            clip      = 1'b1;
        end else begin
            duty_calc = CNT_W'(raw);
            clip      = 1'b0;
        end
    end

    // keep the sampled current and whether the duty was limited
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_samp <= '0;
            sat    <= 1'b0;
        end else if (samp) begin
            i_samp <= adc_i;
            sat    <= clip;
        end
    end
endmodule

// File: rtl/bk_volt_loop.sv
// Slow voltage loop: per-period filter, rate divider, PI law with droop.
// Assumes: wrap pulses once per carrier period; sat reflects the last duty result.
module bk_volt_loop #(
    parameter int DW    = 12,
    parameter int GW    = 8,
    parameter int DIV_W = 8,
    parameter int SH    = 4,
    parameter int FSH   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap,
    input  logic [DW-1:0]    adc_v,
    input  logic [DW-1:0]    vref,
    input  logic [GW-1:0]    kp,
    input  logic [GW-1:0]    ki,
    input  logic [GW-1:0]    kdroop,
    input  logic [DIV_W-1:0] vdiv,
    input  logic [DW-1:0]    i_samp,
    input  logic             sat,
    output logic [DW-1:0]    i_set,
    output logic [DW-1:0]    integ,
    output logic             vstb
);
    localparam int MW = DW + 2*GW + 4;
    localparam logic signed [MW-1:0] TOP_X = MW'((2**DW) - 1);
    localparam logic signed [MW-1:0] ZERO_X = '0;

    logic [DW-1:0]        vf, vf_nx;
    logic signed [DW+1:0] dv;
    logic [DIV_W-1:0]     vcnt;
    logic [DW+GW-1:0]     dprod, droop_v;
    logic signed [MW-1:0] err, kp_x, ki_x, p_t, i_inc, isum, integ_nx, outv;
    logic [DW-1:0]        iset_nx;

    // first-order smoothing step of the voltage reading
    always_comb begin
        dv    = $signed({2'b00, adc_v}) - $signed({2'b00, vf});
        vf_nx = DW'($signed({2'b00, vf}) + (dv >>> FSH));
    end

    // PI law with droop and the integrator hold
    always_comb begin
        dprod   = (DW+GW)'(kdroop) * (DW+GW)'(i_samp);
        droop_v = dprod >> SH;
        err     = MW'(vref) - MW'(droop_v) - MW'(vf);
        kp_x    = MW'(kp);
        ki_x    = MW'(ki);
        p_t     = (kp_x * err) >>> SH;
        i_inc   = (ki_x * err) >>> SH;
        isum    = MW'(integ) + i_inc;
        if (sat)
            integ_nx = MW'(integ);
        else if (isum < ZERO_X)
            integ_nx = ZERO_X;
        else if (isum > TOP_X)
            integ_nx = TOP_X;
        else
            integ_nx = isum;
        outv = p_t + integ_nx;
        if (outv < ZERO_X)
            iset_nx = '0;
        else if (outv > TOP_X)
            iset_nx = DW'(TOP_X);
        else
            iset_nx = DW'(outv);
    end

    // filter update and rate divider, both stepped once per period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vf   <= '0;
            vcnt <= '0;
            vstb <= 1'b0;
        end else begin
            vstb <= 1'b0;
            if (wrap) begin
                vf <= vf_nx;
                if (vcnt >= vdiv) begin
                    vcnt <= '0;
                    vstb <= 1'b1;
                end else begin
                    vcnt <= vcnt + DIV_W'(1);
                end
            end
        end
    end

    // setpoint and integrator update on the divided strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            integ <= '0;
            i_set <= '0;
        end else if (vstb) begin
            integ <= DW'(integ_nx);
            i_set <= iset_nx;
        end
    end
endmodule

// File: rtl/buck_cascade_ctrl.sv
// Top level: carrier, inner proportional current loop and outer PI voltage loop.
// Assumes: adc_i and adc_v are converted samples, refreshed at any rate.
module buck_cascade_ctrl
    import buck_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DW    = 12,
    parameter int GW    = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_duty_min,
    input  logic [CNT_W-1:0] cfg_duty_max,
    input  logic [DW-1:0]    cfg_ilimit,
    input  logic [DW-1:0]    cfg_vref,
    input  logic [GW-1:0]    cfg_kp_i,
    input  logic [GW-1:0]    cfg_kp_v,
    input  logic [GW-1:0]    cfg_ki_v,
    input  logic [GW-1:0]    cfg_kdroop,
    input  logic [DIV_W-1:0] cfg_vdiv,
    input  logic [DW-1:0]    adc_i,
    input  logic [DW-1:0]    adc_v,
    output logic             pwm_out,
    output logic             sample_strobe,
    output logic [CNT_W-1:0] duty_now,
    output logic             oc_trip,
    output logic [DW-1:0]    i_set
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] duty_calc;
    logic [DW-1:0]    i_samp;
    logic [DW-1:0]    integ;
    logic             wrap;
    logic             sat_q;
    logic             vstb;

    bk_pwm_carrier #(.CNT_W(CNT_W), .DW(DW)) u_carrier (
        .clk      (clk),
        .rst_n    (rst_n),
        .period   (cfg_period),
        .duty_calc(duty_calc),
        .adc_i    (adc_i),
        .ilimit   (cfg_ilimit),
        .pwm_out  (pwm_out),
        .samp     (sample_strobe),
        .wrap     (wrap),
        .cnt      (cnt),
        .duty_act (duty_now),
        .kill     (oc_trip)
    );

    bk_cur_loop #(.CNT_W(CNT_W), .DW(DW), .GW(GW), .SH(GAIN_SH)) u_cur (
        .clk      (clk),
        .rst_n    (rst_n),
        .samp     (sample_strobe),
        .adc_i    (adc_i),
        .i_set    (i_set),
        .kp       (cfg_kp_i),
        .dmin     (cfg_duty_min),
        .dmax     (cfg_duty_max),
        .duty_calc(duty_calc),
        .i_samp   (i_samp),
        .sat      (sat_q)
    );

    bk_volt_loop #(.DW(DW), .GW(GW), .DIV_W(DIV_W), .SH(GAIN_SH), .FSH(FILT_SH)) u_volt (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrap   (wrap),
        .adc_v  (adc_v),
        .vref   (cfg_vref),
        .kp     (cfg_kp_v),
        .ki     (cfg_ki_v),
        .kdroop (cfg_kdroop),
        .vdiv   (cfg_vdiv),
        .i_samp (i_samp),
        .sat    (sat_q),
        .i_set  (i_set),
        .integ  (integ),
        .vstb   (vstb)
    );
endmodule

// File: rtl/buck_cascade_ctrl_chk.sv
// Property checker for buck_cascade_ctrl, attached by bind.
// Assumes: observes only; drives nothing in the design.
module buck_cascade_ctrl_chk #(
    parameter int CNT_W = 8,
    parameter int DW    = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwm_out,
    input logic             sample_strobe,
    input logic [CNT_W-1:0] duty_now,
    input logic             oc_trip,
    input logic [DW-1:0]    i_set,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cfg_period,
    input logic [DW-1:0]    adc_i,
    input logic [DW-1:0]    cfg_ilimit,
    input logic             vstb,
    input logic             sat_q,
    input logic [DW-1:0]    integ
);
    logic seen;

    // remembers whether this period has already produced a strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen <= 1'b0;
        else if (cnt >= cfg_period)
            seen <= 1'b0;
        else if (sample_strobe)
            seen <= 1'b1;
    end

    assert_one_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |-> !seen);

    assert_duty_at_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(duty_now) |-> $past(cnt >= cfg_period));

    assert_oc_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        oc_trip |-> !pwm_out);

    assert_oc_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oc_trip) |-> $past(pwm_out) && $past(adc_i > cfg_ilimit));

    assert_iset_on_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(i_set) |-> $past(vstb));

    assert_integ_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (vstb && sat_q) |=> $stable(integ));
endmodule

bind buck_cascade_ctrl buck_cascade_ctrl_chk #(.CNT_W(CNT_W), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwm_out      (pwm_out),
    .sample_strobe(sample_strobe),
    .duty_now     (duty_now),
    .oc_trip      (oc_trip),
    .i_set        (i_set),
    .cnt          (cnt),
    .cfg_period   (cfg_period),
    .adc_i        (adc_i),
    .cfg_ilimit   (cfg_ilimit),
    .vstb         (vstb),
    .sat_q        (sat_q),
    .integ        (integ)
);

// File: tb/sim_buck_cascade_ctrl.sv
// Scoreboard bench for buck_cascade_ctrl: expectations queued, results compared.
module sim_buck_cascade_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_period, cfg_duty_min, cfg_duty_max;
    logic [11:0] cfg_ilimit, cfg_vref;
    logic [7:0]  cfg_kp_i, cfg_kp_v, cfg_ki_v, cfg_kdroop, cfg_vdiv;
    logic [11:0] adc_i, adc_v;
    logic        pwm_out, sample_strobe, oc_trip;
    logic [7:0]  duty_now;
    logic [11:0] i_set;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        string tag;
        int    val;
    } exp_t;
    exp_t sbq[$];

    always #4 clk = ~clk;

    buck_cascade_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_period(cfg_period), .cfg_duty_min(cfg_duty_min), .cfg_duty_max(cfg_duty_max),
        .cfg_ilimit(cfg_ilimit), .cfg_vref(cfg_vref), .cfg_kp_i(cfg_kp_i),
        .cfg_kp_v(cfg_kp_v), .cfg_ki_v(cfg_ki_v), .cfg_kdroop(cfg_kdroop),
        .cfg_vdiv(cfg_vdiv), .adc_i(adc_i), .adc_v(adc_v),
        .pwm_out(pwm_out), .sample_strobe(sample_strobe), .duty_now(duty_now),
        .oc_trip(oc_trip), .i_set(i_set)
    );

    // driver side: queue an expected item
    task automatic push_exp(input string tag, input int v);
        exp_t e;
        e.tag = tag;
        e.val = v;
        sbq.push_back(e);
    endtask

    // monitor side: pop the oldest expectation and compare
    task automatic judge(input int act);
        exp_t e;
        checks++;
        if (sbq.size() == 0) begin
            errors++;
            $display("FAIL scoreboard empty actual=%0d", act);
        end else begin
            e = sbq.pop_front();
            if (act != e.val) begin
                errors++;
                $display("FAIL %s actual=%0d expected=%0d", e.tag, act, e.val);
            end
        end
    endtask

    task automatic wait_periods(input int n);
        repeat (n * 100) @(negedge clk);
    endtask

    // align to a pulse start and observe one whole period
    task automatic measure(input int chg_at, input int chg_val,
                           output int highs, output int spos,
                           output int scnt, output int oc5);
        logic prev;
        bit   ok;
        ok    = 0;
        prev  = pwm_out;
        highs = 0;
        spos  = -1;
        scnt  = 0;
        oc5   = 0;
        for (int k = 0; k < 400 && !ok; k++) begin
            @(negedge clk);
            if (pwm_out && !prev) ok = 1;
            else prev = pwm_out;
        end
        if (!ok) begin
            highs = -1;
            return;
        end
        for (int k = 0; k < 100; k++) begin
            if (k > 0) @(negedge clk);
            if (k == chg_at) adc_i = 12'(chg_val);
            if (pwm_out) highs++;
            if (sample_strobe) begin
                scnt++;
                spos = k;
            end
            if (k == 5) oc5 = int'(oc_trip);
        end
    endtask

    // watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int h, sp, sc, o5, last, chg, bad, frz;
        cfg_period = 8'd99; cfg_duty_min = 8'd2; cfg_duty_max = 8'd90;
        cfg_ilimit = 12'd4095; cfg_vref = 12'd64;
        cfg_kp_i = 8'd16; cfg_kp_v = 8'd16; cfg_ki_v = 8'd0; cfg_kdroop = 8'd0;
        cfg_vdiv = 8'd0; adc_i = 12'd24; adc_v = 12'd0;

        // R12: outputs held at zero during reset
        repeat (5) @(negedge clk);
        push_exp("R12 pwm_out", 0);  judge(int'(pwm_out));
        push_exp("R12 oc_trip", 0);  judge(int'(oc_trip));
        push_exp("R12 duty_now", 0); judge(int'(duty_now));
        push_exp("R12 i_set", 0);    judge(int'(i_set));
        rst_n = 1'b1;

        // R1 R3: i_set = 64, duty = 16*(64-24)>>4 = 40
        wait_periods(6);
        measure(-1, 0, h, sp, sc, o5);
        push_exp("R1 high clocks", 40); judge(h);
        push_exp("R3 duty_now", 40);    judge(int'(duty_now));
        // R2: single strobe on the final high clock
        push_exp("R2 strobe count", 1);    judge(sc);
        push_exp("R2 strobe position", 39); judge(sp);

        // R4: current changed mid-period; effect only in the next period
        measure(2, 44, h, sp, sc, o5);
        push_exp("R4 current period", 40); judge(h);
        measure(-1, 0, h, sp, sc, o5);
        push_exp("R4 next period", 20);    judge(h);

        // R5: below minimum, then above maximum
        adc_i = 12'd80;
        wait_periods(3);
        measure(-1, 0, h, sp, sc, o5);
        push_exp("R5 min clamp", 2); judge(h);
        cfg_duty_max = 8'd50; adc_i = 12'd0;
        wait_periods(3);
        measure(-1, 0, h, sp, sc, o5);
        push_exp("R5 max clamp", 50); judge(h);

        // R6: overcurrent cuts the pulse after one clock, strobe still at 28
        cfg_duty_max = 8'd90; cfg_ilimit = 12'd30; adc_i = 12'd35;
        wait_periods(3);
        measure(-1, 0, h, sp, sc, o5);
        push_exp("R6 high clocks", 1);   judge(h);
        push_exp("R6 oc_trip", 1);       judge(o5);
        push_exp("R6 strobe position", 28); judge(sp);
        cfg_ilimit = 12'd4095; adc_i = 12'd24;
        wait_periods(3);
        measure(-1, 0, h, sp, sc, o5);
        push_exp("R6 released", 40); judge(h);

        // R7 R9: integral only, +4 per update, update every 4 periods
        cfg_kp_v = 8'd0; cfg_ki_v = 8'd16; cfg_vref = 12'd4;
        cfg_kp_i = 8'd0; cfg_duty_min = 8'd0; adc_i = 12'd0; cfg_vdiv = 8'd3;
        wait_periods(8);
        last = int'(i_set); chg = 0; bad = 0;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            if (int'(i_set) != last) begin
                chg++;
                if (int'(i_set) - last != 4) bad++;
                last = int'(i_set);
            end
        end
        push_exp("R7 updates in 40 periods", 10); judge(chg);
        push_exp("R9 integral steps not 4", 0);   judge(bad);

        // R11: limited duty freezes the integrator
        cfg_duty_min = 8'd5;
        wait_periods(5);
        frz = int'(i_set);
        wait_periods(20);
        push_exp("R11 integrator held", frz); judge(int'(i_set));
        measure(-1, 0, h, sp, sc, o5);
        push_exp("R5 min with zero gain", 5); judge(h);

        // R10: droop = 16*16>>4 = 16, i_set = 64-16 + held integrator
        cfg_ki_v = 8'd0; cfg_duty_min = 8'd0; cfg_kp_v = 8'd16;
        cfg_kdroop = 8'd16; adc_i = 12'd16; cfg_vref = 12'd64; cfg_vdiv = 8'd0;
        wait_periods(10);
        push_exp("R10 droop setpoint", 48 + frz); judge(int'(i_set));

        // R8: voltage step to 32, filter climbs 8,14,... and stops at 29
        cfg_kdroop = 8'd0; adc_v = 12'd32;
        repeat (150) @(negedge clk);
        push_exp("R8 early filtered", 1);
        judge(int'(int'(i_set) >= 50 + frz && int'(i_set) <= 56 + frz));
        wait_periods(40);
        push_exp("R8 settled", 35 + frz); judge(int'(i_set));

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule